// File: doc/BRIEF.md
# Decimation Filter Control Sequencer

This block sequences a decimating digital filter that sits behind a delta-sigma modulator. It samples a reset request, a power-down request and a sync request on every rising edge of the input clock. From these it decides whether the convolution engine is cleared, idle, running or frozen. While the block is idle or running, it generates the modulator clock and a one-cycle modulator sync pulse. It captures the modulator data and flag bits on the rising edges of that clock. It also owns the filter's result, offset, configuration and status registers. It clears or loads them during reset and keeps them through power-down. A countdown tells the clock source when the input clock may be stopped.

An asynchronous power-on input places the block in its initial reset state. After that, the request pins are sampled synchronously. Filter results arrive on a valid/ready stream. The block raises ready only while convolution runs, so the producer must hold its word until it sees ready. A word offered at any other time is neither accepted nor lost. Host writes to the offset and configuration registers stay open in every state except reset.

Top module: `dfilt_ctrl_seq`

## Requirements
- R1: After the power-on input is released, the block sits in reset. The first clock edge that samples the reset request low moves it straight to idle. If the request is high instead, it stays in reset.
- R2: The first rising edge that samples the reset request high puts the block in reset (`in_reset`=1). In reset, `conv_en`, `mod_clk` and `mod_sync` are 0.
- R3: Once the reset request is low, the block stays in reset through the first rising edge and reaches idle on the second.
- R4: A clock edge taken in reset clears `data_q`, `off_q` and `stat_q` to zero. The same edge copies `cfg_pins` unchanged into `cfg_q`, and host writes are ignored.
- R5: Idle leaves for run only on an edge that samples the sync request high. That edge raises `conv_en` and gives a `mod_sync` pulse of exactly one cycle. A sync request taken in run gives another such pulse.
- R6: A sync request sampled in reset or in power-down changes nothing: `conv_en` and `mod_sync` stay 0.
- R7: The first edge that samples the power-down request high, with no reset request, enters power-down (`pdn_ack`=1). The first edge that samples it low moves to idle, and idle still waits for sync.
- R8: Outside idle and run, `mod_clk` and `mod_sync` are 0 and the modulator inputs are ignored: `mod_bit` and `stat_q` hold. In idle or run, `mod_bit` takes `mod_data` on each edge that raises `mod_clk`. A `mod_flag` value of 1 on such an edge sets `stat_q` to 1, and it stays 1 until reset.
- R9: In idle and run, `mod_clk` equals 1 exactly when k mod DIV ≥ DIV/2. Here k counts the edges since the block entered idle, and DIV defaults to 4.
- R10: Power-down keeps `data_q`, `cfg_q` and `stat_q` unchanged. Host writes still work: `host_sel`=0 writes `off_q`, and `host_sel`=1 writes the low bits of `host_wdata` into `cfg_q`.
- R11: `clk_stop_ok` rises exactly on the 64th edge after the edge that entered power-down. It is 0 before that edge and at every moment outside power-down.
- R12: Priority runs reset over power-down over sync.
- R13: `res_ready` equals `conv_en`. `data_q` takes `res_data` on each edge where `res_valid` and `res_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Reset request, sampled on rising edges |
| pdn_req | input | 1 | Power-down request, sampled on rising edges |
| sync_req | input | 1 | Sync request, sampled on rising edges |
| cfg_pins | input | CFG_W | Hardware configuration levels, copied in reset |
| mod_data | input | 1 | Modulator data bit |
| mod_flag | input | 1 | Modulator flag bit |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Write target: 0 offset, 1 configuration |
| host_wdata | input | DATA_W | Host write data |
| res_valid | input | 1 | Filter result valid |
| res_data | input | DATA_W | Filter result word |
| res_ready | output | 1 | Result stream ready |
| in_reset | output | 1 | Block is in reset |
| idle | output | 1 | Block is idle, waiting for sync |
| conv_en | output | 1 | Convolution engine enabled |
| pdn_ack | output | 1 | Block is in power-down |
| clk_stop_ok | output | 1 | Input clock may be stopped |
| mod_clk | output | 1 | Modulator clock |
| mod_sync | output | 1 | Modulator sync pulse |
| mod_bit | output | 1 | Last captured modulator data bit |
| data_q | output | DATA_W | Data output register |
| off_q | output | DATA_W | Offset register |
| cfg_q | output | CFG_W | Configuration register |
| stat_q | output | 1 | Sticky modulator flag status |

## Verification
Directed edge counts for reset entry, the two-edge reset exit, power-down entry and exit, and the 64-edge stop flag catch any added or missing register stage. Held request patterns are used where reset, power-down and sync arrive together. These separate a correct priority order from any other ordering. Random result words with random valid timing, and random host values, show whether data loads only during run. Toggling the modulator inputs and the sync request during power-down shows whether those inputs are ignored and whether registers are retained or disturbed.

// File: rtl/dfseq_pkg.sv
package dfseq_pkg;
  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_RST  = 3'd1,
    ST_RST2 = 3'd2,
    ST_IDLE = 3'd3,
    ST_RUN  = 3'd4,
    ST_PDN  = 3'd5
  } seq_st_e;
endpackage

// File: rtl/dfseq_fsm.sv
module dfseq_fsm
  import dfseq_pkg::*;
(
  input  logic    clk,
  input  logic    por_n,
  input  logic    rst_req,
  input  logic    pdn_req,
  input  logic    sync_req,
  output seq_st_e st,
  output logic    sync_pulse
);
  seq_st_e st_nx;
  logic    sync_go;

  always_comb begin
    st_nx = st;
    if (rst_req) st_nx = ST_RST;
    else begin
      case (st)
        ST_POR, ST_RST2: st_nx = pdn_req ? ST_PDN : ST_IDLE;
        ST_RST:          st_nx = ST_RST2;
        ST_IDLE:         st_nx = pdn_req ? ST_PDN : (sync_req ? ST_RUN : ST_IDLE);
        ST_RUN:          st_nx = pdn_req ? ST_PDN : ST_RUN;
        ST_PDN:          st_nx = pdn_req ? ST_PDN : ST_IDLE;
        default:         st_nx = ST_RST;
      endcase
    end
  end

  assign sync_go = sync_req && !rst_req && !pdn_req && (st == ST_IDLE || st == ST_RUN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st         <= ST_POR;
      sync_pulse <= 1'b0;
    end else begin
      st         <= st_nx;
      sync_pulse <= sync_go;
    end
  end

  p_reset_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> (st == ST_RST));
  p_exit_first_r3: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RST && !rst_req) |=> (st == ST_RST2));
  p_exit_second_r3: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RST2 && !rst_req && !pdn_req) |=> (st == ST_IDLE));
  p_run_needs_sync_r5: assert property (@(posedge clk) disable iff (!por_n)
    (st != ST_RUN) ##1 (st == ST_RUN) |-> $past(sync_req));
  p_pdn_entry_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_req && pdn_req && st != ST_RST) |=> (st == ST_PDN));
  p_rst_priority_r12: assert property (@(posedge clk) disable iff (!por_n)
    (rst_req && pdn_req) |=> (st == ST_RST && !sync_pulse));
endmodule

// File: rtl/dfseq_modclk.sv
module dfseq_modclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic active,
  input  logic sync_pulse,
  input  logic mod_data,
  input  logic mod_flag,
  output logic mod_clk,
  output logic mod_sync,
  output logic mod_bit,
  output logic flag_hit
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic          cap_now;

  assign cap_now  = active && (div_cnt == CW'(HALF - 1));
  assign flag_hit = cap_now && mod_flag;
  assign mod_clk  = active && (div_cnt >= CW'(HALF));
  assign mod_sync = sync_pulse;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      div_cnt <= '0;
      mod_bit <= 1'b0;
    end else begin
      if (!active) div_cnt <= '0;
      else if (div_cnt == CW'(DIV - 1)) div_cnt <= '0;
      else div_cnt <= div_cnt + 1'b1;
      if (cap_now) mod_bit <= mod_data;
    end
  end

  p_quiet_outputs_r8: assert property (@(posedge clk) disable iff (!por_n)
    !active |-> (!mod_clk && !mod_sync));
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !active |=> $stable(mod_bit));
  p_clock_low_on_entry_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!active ##1 active) |-> !mod_clk);
endmodule

// File: rtl/dfseq_shut_timer.sv
module dfseq_shut_timer #(
  parameter int SHUT_CYC = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic pdn,
  output logic stop_ok
);
  localparam int TW = $clog2(SHUT_CYC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt <= '0;
    else if (!pdn) cnt <= '0;
    else if (cnt != TW'(SHUT_CYC)) cnt <= cnt + 1'b1;
  end

  assign stop_ok = pdn && (cnt == TW'(SHUT_CYC));

  p_stop_only_in_pdn_r11: assert property (@(posedge clk) disable iff (!por_n)
    stop_ok |-> pdn);
  p_stop_not_on_entry_r11: assert property (@(posedge clk) disable iff (!por_n)
    (!pdn ##1 pdn) |-> !stop_ok);
endmodule

// File: rtl/dfseq_regs.sv
module dfseq_regs #(
  parameter int DATA_W = 24,
  parameter int CFG_W  = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr,
  input  logic              hold,
  input  logic [CFG_W-1:0]  cfg_pins,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              res_valid,
  input  logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              flag_hit,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] off_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              stat_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q <= '0;
      off_q  <= '0;
      cfg_q  <= '0;
      stat_q <= 1'b0;
    end else if (clr) begin
      data_q <= '0;
      off_q  <= '0;
      cfg_q  <= cfg_pins;
      stat_q <= 1'b0;
    end else begin
      if (res_valid && res_ready) data_q <= res_data;
      if (host_wr && host_sel)  cfg_q <= host_wdata[CFG_W-1:0];
      if (host_wr && !host_sel) off_q <= host_wdata;
      if (flag_hit) stat_q <= 1'b1;
    end
  end

  p_clear_load_r4: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (data_q == '0 && off_q == '0 && !stat_q && cfg_q == $past(cfg_pins)));
  p_retain_in_pdn_r10: assert property (@(posedge clk) disable iff (!por_n)
    (hold && !clr) |=> ($stable(data_q) && $stable(stat_q)));
endmodule

// File: rtl/dfilt_ctrl_seq.sv
module dfilt_ctrl_seq
  import dfseq_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CFG_W    = 7,
  parameter int DIV      = 4,
  parameter int SHUT_CYC = 64
) (
  input  logic              clk_in,
  input  logic              por_n,
  input  logic              rst_req,
  input  logic              pdn_req,
  input  logic              sync_req,
  input  logic [CFG_W-1:0]  cfg_pins,
  input  logic              mod_data,
  input  logic              mod_flag,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  output logic              in_reset,
  output logic              idle,
  output logic              conv_en,
  output logic              pdn_ack,
  output logic              clk_stop_ok,
  output logic              mod_clk,
  output logic              mod_sync,
  output logic              mod_bit,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] off_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              stat_q
);
  seq_st_e st;
  logic    sync_pulse;
  logic    active;
  logic    flag_hit;

  dfseq_fsm u_fsm (
    .clk        (clk_in),
    .por_n      (por_n),
    .rst_req    (rst_req),
    .pdn_req    (pdn_req),
    .sync_req   (sync_req),
    .st         (st),
    .sync_pulse (sync_pulse)
  );

  assign in_reset  = (st == ST_POR) || (st == ST_RST) || (st == ST_RST2);
  assign idle      = (st == ST_IDLE);
  assign conv_en   = (st == ST_RUN);
  assign pdn_ack   = (st == ST_PDN);
  assign active    = idle || conv_en;
  assign res_ready = conv_en;

  dfseq_modclk #(.DIV(DIV)) u_modclk (
    .clk        (clk_in),
    .por_n      (por_n),
    .active     (active),
    .sync_pulse (sync_pulse),
    .mod_data   (mod_data),
    .mod_flag   (mod_flag),
    .mod_clk    (mod_clk),
    .mod_sync   (mod_sync),
    .mod_bit    (mod_bit),
    .flag_hit   (flag_hit)
  );

  dfseq_shut_timer #(.SHUT_CYC(SHUT_CYC)) u_timer (
    .clk     (clk_in),
    .por_n   (por_n),
    .pdn     (pdn_ack),
    .stop_ok (clk_stop_ok)
  );

  dfseq_regs #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk        (clk_in),
    .por_n      (por_n),
    .clr        (in_reset),
    .hold       (pdn_ack),
    .cfg_pins   (cfg_pins),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_data   (res_data),
    .flag_hit   (flag_hit),
    .data_q     (data_q),
    .off_q      (off_q),
    .cfg_q      (cfg_q),
    .stat_q     (stat_q)
  );

  p_ready_tracks_run_r13: assert property (@(posedge clk_in) disable iff (!por_n)
    (res_ready && res_valid && !rst_req) |=> (data_q == $past(res_data)));
  p_exit_pdn_to_idle_r7: assert property (@(posedge clk_in) disable iff (!por_n)
    (pdn_ack && !pdn_req && !rst_req) |=> (idle && !conv_en));
endmodule

// File: tb/dfilt_ctrl_seq_tb.sv
module dfilt_ctrl_seq_tb;
  localparam int DATA_W = 24;
  localparam int CFG_W  = 7;
  localparam int DIV    = 4;
  localparam int SHUT   = 64;

  logic              clk_in = 1'b0;
  logic              por_n, rst_req, pdn_req, sync_req;
  logic [CFG_W-1:0]  cfg_pins;
  logic              mod_data, mod_flag, host_wr, host_sel, res_valid;
  logic [DATA_W-1:0] host_wdata, res_data;
  logic              res_ready, in_reset, idle, conv_en, pdn_ack, clk_stop_ok;
  logic              mod_clk, mod_sync, mod_bit, stat_q;
  logic [DATA_W-1:0] data_q, off_q;
  logic [CFG_W-1:0]  cfg_q;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_in = ~clk_in;

  dfilt_ctrl_seq #(.DATA_W(DATA_W), .CFG_W(CFG_W), .DIV(DIV), .SHUT_CYC(SHUT)) u_dut (
    .clk_in(clk_in), .por_n(por_n), .rst_req(rst_req), .pdn_req(pdn_req),
    .sync_req(sync_req), .cfg_pins(cfg_pins), .mod_data(mod_data), .mod_flag(mod_flag),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .in_reset(in_reset), .idle(idle), .conv_en(conv_en), .pdn_ack(pdn_ack),
    .clk_stop_ok(clk_stop_ok), .mod_clk(mod_clk), .mod_sync(mod_sync),
    .mod_bit(mod_bit), .data_q(data_q), .off_q(off_q), .cfg_q(cfg_q), .stat_q(stat_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_in);
    #1;
  endtask

  function automatic logic exp_mclk(input int k);
    return (k % DIV) >= (DIV / 2);
  endfunction

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] exp_data, exp_off;
    logic [CFG_W-1:0]  exp_cfg;
    logic              exp_bit;
    void'($urandom(32'h5EED_0042));
    por_n = 1'b0; rst_req = 1'b0; pdn_req = 1'b0; sync_req = 1'b0;
    cfg_pins = 7'h5A; mod_data = 1'b0; mod_flag = 1'b0;
    host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    res_valid = 1'b0; res_data = '0;
    #13;
    chk("R1 in_reset at power-up", 32'(in_reset), 32'd1);
    chk("R2 mod_clk low in reset", 32'(mod_clk), 32'd0);
    chk("R1 data_q zero at power-up", 32'(data_q), 32'd0);
    tick();
    por_n = 1'b1;
    mod_data = 1'b1;
    tick();
    chk("R1 first edge with reset low gives idle", 32'(idle), 32'd1);
    chk("R4 cfg loaded from pins", 32'(cfg_q), 32'h5A);
    chk("R9 mod_clk k=0", 32'(mod_clk), 32'(exp_mclk(0)));
    for (int k = 1; k < 8; k++) begin
      tick();
      chk("R9 mod_clk divided", 32'(mod_clk), 32'(exp_mclk(k)));
    end
    chk("R8 mod_bit captured", 32'(mod_bit), 32'd1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 idle waits for sync", 32'(conv_en), 32'd0);
    end
    sync_req = 1'b1;
    tick();
    sync_req = 1'b0;
    chk("R5 run after sync", 32'(conv_en), 32'd1);
    chk("R5 mod_sync pulse", 32'(mod_sync), 32'd1);
    tick();
    chk("R5 mod_sync one cycle", 32'(mod_sync), 32'd0);
    chk("R13 ready in run", 32'(res_ready), 32'd1);
    exp_data = data_q;
    exp_off  = off_q;
    for (int i = 0; i < 40; i++) begin
      res_valid  = 1'($urandom);
      res_data   = DATA_W'($urandom);
      host_wr    = 1'($urandom);
      host_sel   = 1'b0;
      host_wdata = DATA_W'($urandom);
      if (res_valid) exp_data = res_data;
      if (host_wr) exp_off = host_wdata;
      tick();
      chk("R13 stream load", 32'(data_q), 32'(exp_data));
      chk("R10 offset write", 32'(off_q), 32'(exp_off));
    end
    res_valid = 1'b0; host_wr = 1'b0;
    mod_flag = 1'b1;
    for (int k = 0; k < DIV; k++) tick();
    mod_flag = 1'b0;
    chk("R8 flag sets status", 32'(stat_q), 32'd1);
    exp_bit = mod_bit;
    exp_cfg = cfg_q;
    pdn_req = 1'b1;
    tick();
    chk("R7 pdn entry edge", 32'(pdn_ack), 32'd1);
    chk("R8 mod_clk low in pdn", 32'(mod_clk), 32'd0);
    chk("R11 stop flag low at entry", 32'(clk_stop_ok), 32'd0);
    for (int n = 1; n <= SHUT; n++) begin
      mod_data  = 1'($urandom);
      mod_flag  = 1'($urandom);
      sync_req  = 1'($urandom);
      res_valid = 1'($urandom);
      res_data  = DATA_W'($urandom);
      host_wr   = (n == 10);
      host_sel  = 1'b0;
      host_wdata = 24'h000123;
      if (n == 10) exp_off = 24'h000123;
      tick();
      chk("R11 stop flag timing", 32'(clk_stop_ok), 32'(n == SHUT));
      chk("R6 sync ignored in pdn", 32'({conv_en, mod_sync}), 32'd0);
      chk("R8 mod_bit held in pdn", 32'(mod_bit), 32'(exp_bit));
      chk("R10 data retained", 32'(data_q), 32'(exp_data));
    end
    host_wr = 1'b0; sync_req = 1'b0; res_valid = 1'b0; mod_flag = 1'b0;
    chk("R10 offset written in pdn", 32'(off_q), 32'h123);
    chk("R10 cfg retained", 32'(cfg_q), 32'(exp_cfg));
    chk("R10 status retained", 32'(stat_q), 32'd1);
    pdn_req = 1'b0;
    tick();
    chk("R7 pdn exit to idle", 32'({idle, pdn_ack, conv_en}), 32'b100);
    chk("R11 stop flag drops", 32'(clk_stop_ok), 32'd0);
    chk("R10 data after pdn", 32'(data_q), 32'(exp_data));
    pdn_req = 1'b1; sync_req = 1'b1;
    tick();
    chk("R12 pdn over sync", 32'({pdn_ack, conv_en, mod_sync}), 32'b100);
    pdn_req = 1'b0; sync_req = 1'b0;
    tick();
    chk("R7 idle after pdn", 32'(idle), 32'd1);
    cfg_pins = 7'h25;
    rst_req = 1'b1; pdn_req = 1'b1; sync_req = 1'b1;
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = 24'h00007F;
    tick();
    chk("R12 reset over pdn and sync", 32'({in_reset, pdn_ack, conv_en}), 32'b100);
    chk("R2 reset entry edge", 32'(in_reset), 32'd1);
    tick();
    chk("R4 data cleared", 32'(data_q), 32'd0);
    chk("R4 offset cleared", 32'(off_q), 32'd0);
    chk("R4 status cleared", 32'(stat_q), 32'd0);
    chk("R4 cfg from pins, host write ignored", 32'(cfg_q), 32'h25);
    chk("R6 sync ignored in reset", 32'({conv_en, mod_sync}), 32'd0);
    rst_req = 1'b0; pdn_req = 1'b0; sync_req = 1'b0; host_wr = 1'b0;
    tick();
    chk("R3 still in reset after first edge", 32'(in_reset), 32'd1);
    tick();
    chk("R3 idle on second edge", 32'({idle, in_reset}), 32'b10);
    por_n = 1'b0;
    rst_req = 1'b1;
    #2;
    chk("R1 power-on forces reset", 32'(in_reset), 32'd1);
    tick();
    por_n = 1'b1;
    tick();
    chk("R1 reset held when request high", 32'({in_reset, idle}), 32'b10);
    rst_req = 1'b0;
    tick();
    tick();
    chk("R3 idle after power-on reset", 32'(idle), 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule